// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table held in ordinary memory. A client hands it one request at a time. Each request carries the virtual address, an access kind (read, write or execute) and the frame number of the top-level table. The walker fetches a top-level entry and then, if that entry is present, the matching second-level (leaf) entry. It checks the leaf for presence and permission. It then answers with either a physical address or a fault code.

On a permitted access the walker marks the leaf entry as used, and also as changed when the access is a write. It does this by writing the updated entry back over the same memory port. The write happens only when one of those two bits actually flips. All traffic goes out through one memory port with a request/ready handshake and a response strobe, and the response may come after any delay. Results are reported by a single-cycle completion pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The virtual address splits into bits 31:22 (top index), 21:12 (leaf index) and 11:0 (page offset). The first read goes to `req_root*4096 + top_index*4`. The second read goes to `F*4096 + leaf_index*4`, where F is bits 31:12 of the top-level entry. Entries are 32 bits wide. Bit 0 is present, bit 1 is read-allowed, bit 2 is write-allowed, bit 3 is execute-allowed, bit 5 is used, bit 6 is changed, and bits 31:12 hold the frame number.
- R3: A top-level entry with bit 0 clear ends the walk with fault code 01 (not present) and `done_paddr` 0. No second read is made.
- R4: A leaf entry with bit 0 clear ends the walk with fault code 01, and no write is made.
- R5: Access codes are 00 read, 01 write, 10 execute and 11 read. Each needs the matching leaf bit (1, 2 or 3). If that bit is missing, the result is fault code 10 (protection), `done_paddr` 0, and no write. Permission bits of top-level entries are ignored.
- R6: A permitted walk ends with fault code 00 and `done_paddr` = {leaf bits 31:12, virtual bits 11:0}.
- R7: On a permitted walk, the leaf is written back to its own address with bit 5 set, and with bit 6 also set for access code 01. All other bits are kept. The write is made only if this changes the entry.
- R8: A memory request holds `mem_req_valid`, address, write flag and write data steady until `mem_req_ready`. A read waits for `mem_rsp_valid` however late it comes.
- R9: `done` is high for exactly one cycle. It rises in the cycle after the last memory event of the walk: the accepted response, or the accepted write-back.
- R10: `req_ready` is 1 only while idle. Once a request is taken, `req_ready` stays 0 until the `done` cycle, and `req_valid` is ignored in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 read |
| req_root | input | 20 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_write | output | 1 | 1 for the leaf write-back, 0 for a read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated leaf entry for the write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, 0 on a fault |
| done_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The bench times every result from the memory events it drives itself. It raises `mem_rsp_valid` or `mem_req_ready` at a falling edge, so the walker consumes the event at the next rising edge. The completion is therefore due at the falling edge one full cycle later. The bench marks that cycle in advance and checks that `done` is high then and at no other sampling point. Each memory access is compared with the next access a behavioural walk predicts, in the cycle the bench accepts it. A stalled access is re-checked for stability one cycle on. `req_ready` is checked to be low at every falling edge from the cycle after acceptance up to the completion cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    parameter int VA_W     = 32;
    parameter int PA_W     = 32;
    parameter int PTE_W    = 32;
    parameter int L1_BITS  = 10;
    parameter int L2_BITS  = 10;
    parameter int OFF_BITS = 12;

    // entry bit positions
    localparam int PTE_V   = 0;
    localparam int PTE_R   = 1;
    localparam int PTE_W_B = 2;
    localparam int PTE_X   = 3;
    localparam int PTE_REF = 5;
    localparam int PTE_MOD = 6;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RD2 = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PERM   = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_WB_REQ
    } walk_st_e;

endpackage

// File: rtl/pw_va_split.sv
module pw_va_split #(
    parameter int VA_W     = pt_walker_pkg::VA_W,
    parameter int L1_BITS  = pt_walker_pkg::L1_BITS,
    parameter int L2_BITS  = pt_walker_pkg::L2_BITS,
    parameter int OFF_BITS = pt_walker_pkg::OFF_BITS
) (
    input  logic [VA_W-1:0]     va,
    output logic [L1_BITS-1:0]  top_idx,
    output logic [L2_BITS-1:0]  leaf_idx,
    output logic [OFF_BITS-1:0] pg_off
);

    localparam int LEAF_LSB = OFF_BITS;
    localparam int TOP_LSB  = OFF_BITS + L2_BITS;

    assign top_idx  = va[TOP_LSB +: L1_BITS];
    assign leaf_idx = va[LEAF_LSB +: L2_BITS];
    assign pg_off   = va[OFF_BITS-1:0];

endmodule

// File: rtl/pw_pte_check.sv
module pw_pte_check
    import pt_walker_pkg::*;
#(
    parameter int PTE_W    = pt_walker_pkg::PTE_W,
    parameter int OFF_BITS = pt_walker_pkg::OFF_BITS
) (
    input  logic [PTE_W-1:0]          pte,
    input  acc_e                      acc,
    output logic                      present,
    output logic                      allowed,
    output logic                      changed,
    output logic [PTE_W-1:0]          pte_upd,
    output logic [PTE_W-OFF_BITS-1:0] frame
);

    localparam int FRAME_W = PTE_W - OFF_BITS;

    always_comb begin
        present = pte[PTE_V];
        frame   = pte[PTE_W-1 -: FRAME_W];

        unique case (acc)
            ACC_WR:  allowed = pte[PTE_W_B];
            ACC_EX:  allowed = pte[PTE_X];
            default: allowed = pte[PTE_R];
        endcase

        pte_upd          = pte;
        pte_upd[PTE_REF] = 1'b1;
        if (acc == ACC_WR) begin
            pte_upd[PTE_MOD] = 1'b1;
        end
        changed = (pte_upd != pte);
    end

endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int VA_W     = pt_walker_pkg::VA_W,
    parameter int PA_W     = pt_walker_pkg::PA_W,
    parameter int PTE_W    = pt_walker_pkg::PTE_W,
    parameter int L1_BITS  = pt_walker_pkg::L1_BITS,
    parameter int L2_BITS  = pt_walker_pkg::L2_BITS,
    parameter int OFF_BITS = pt_walker_pkg::OFF_BITS,
    localparam int PFN_W   = PA_W - OFF_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_acc,
    input  logic [PFN_W-1:0]    req_root,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [PA_W-1:0]     mem_req_addr,
    output logic [PTE_W-1:0]    mem_req_wdata,
    input  logic                mem_rsp_valid,
    output logic                done,
    output logic [PA_W-1:0]     done_paddr,
    output logic [1:0]          done_fault,
    output logic [VA_W-1:0]     va_cur,
    output acc_e                acc_cur,
    input  logic [L1_BITS-1:0]  top_idx,
    input  logic [L2_BITS-1:0]  leaf_idx,
    input  logic [OFF_BITS-1:0] pg_off,
    input  logic                ent_present,
    input  logic                ent_allowed,
    input  logic                ent_changed,
    input  logic [PTE_W-1:0]    ent_updated,
    input  logic [PFN_W-1:0]    ent_frame
);

    localparam int ENT_SHIFT = $clog2(PTE_W / 8);

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   va;
        acc_e              acc;
        logic [PFN_W-1:0]  root;
        logic [PFN_W-1:0]  tbl2;
        logic [PTE_W-1:0]  leaf;
        logic              done;
        logic [PA_W-1:0]   pa;
        fault_e            flt;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [PA_W-1:0] top_addr;
    logic [PA_W-1:0] leaf_addr;

    assign top_addr  = {walk_q.root, {OFF_BITS{1'b0}}} + (PA_W'(top_idx) << ENT_SHIFT);
    assign leaf_addr = {walk_q.tbl2, {OFF_BITS{1'b0}}} + (PA_W'(leaf_idx) << ENT_SHIFT);

    assign req_ready     = (walk_q.st == ST_IDLE);
    assign mem_req_valid = (walk_q.st == ST_L1_REQ) || (walk_q.st == ST_L2_REQ) ||
                           (walk_q.st == ST_WB_REQ);
    assign mem_req_write = (walk_q.st == ST_WB_REQ);
    assign mem_req_addr  = (walk_q.st == ST_L1_REQ) ? top_addr  :
                           mem_req_valid            ? leaf_addr : '0;
    assign mem_req_wdata = (walk_q.st == ST_WB_REQ) ? walk_q.leaf : '0;
    assign done          = walk_q.done;
    assign done_paddr    = walk_q.pa;
    assign done_fault    = walk_q.flt;
    assign va_cur        = walk_q.va;
    assign acc_cur       = walk_q.acc;

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.st   = ST_L1_REQ;
                    walk_d.va   = req_vaddr;
                    walk_d.acc  = acc_e'(req_acc);
                    walk_d.root = req_root;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_L1_WAIT;
                end
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        walk_d.st   = ST_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.flt  = FLT_ABSENT;
                        walk_d.pa   = '0;
                    end else begin
                        walk_d.tbl2 = ent_frame;
                        walk_d.st   = ST_L2_REQ;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) begin
                    walk_d.st = ST_L2_WAIT;
                end
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present || !ent_allowed) begin
                        walk_d.st   = ST_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.flt  = ent_present ? FLT_PERM : FLT_ABSENT;
                        walk_d.pa   = '0;
                    end else if (ent_changed) begin
                        walk_d.leaf = ent_updated;
                        walk_d.st   = ST_WB_REQ;
                    end else begin
                        walk_d.st   = ST_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.flt  = FLT_NONE;
                        walk_d.pa   = {ent_frame, pg_off};
                    end
                end
            end
            ST_WB_REQ: begin
                if (mem_req_ready) begin
                    walk_d.st   = ST_IDLE;
                    walk_d.done = 1'b1;
                    walk_d.flt  = FLT_NONE;
                    walk_d.pa   = {walk_q.leaf[PTE_W-1 -: PFN_W], pg_off};
                end
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q      <= '0;
            walk_q.st   <= ST_IDLE;
            walk_q.acc  <= ACC_RD;
            walk_q.flt  <= FLT_NONE;
        end else begin
            walk_q <= walk_d;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
        $stable(mem_req_write) && $stable(mem_req_wdata)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        done && (done_fault != 2'b00) |-> (done_paddr == '0)); // R3

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R10

    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid && !mem_req_write && !req_ready); // R2

    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[PTE_REF] && mem_req_wdata[PTE_V]); // R7

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W     = pt_walker_pkg::VA_W,
    parameter int PA_W     = pt_walker_pkg::PA_W,
    parameter int PTE_W    = pt_walker_pkg::PTE_W,
    parameter int L1_BITS  = pt_walker_pkg::L1_BITS,
    parameter int L2_BITS  = pt_walker_pkg::L2_BITS,
    parameter int OFF_BITS = pt_walker_pkg::OFF_BITS,
    localparam int PFN_W   = PA_W - OFF_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [PFN_W-1:0] req_root,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic [PA_W-1:0]  done_paddr,
    output logic [1:0]       done_fault
);

    logic [VA_W-1:0]     va_cur;
    acc_e                acc_cur;
    logic [L1_BITS-1:0]  top_idx;
    logic [L2_BITS-1:0]  leaf_idx;
    logic [OFF_BITS-1:0] pg_off;
    logic                ent_present;
    logic                ent_allowed;
    logic                ent_changed;
    logic [PTE_W-1:0]    ent_updated;
    logic [PFN_W-1:0]    ent_frame;

    pw_va_split #(
        .VA_W(VA_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS)
    ) u_split (
        .va       (va_cur),
        .top_idx  (top_idx),
        .leaf_idx (leaf_idx),
        .pg_off   (pg_off)
    );

    pw_pte_check #(
        .PTE_W(PTE_W), .OFF_BITS(OFF_BITS)
    ) u_check (
        .pte     (mem_rsp_data),
        .acc     (acc_cur),
        .present (ent_present),
        .allowed (ent_allowed),
        .changed (ent_changed),
        .pte_upd (ent_updated),
        .frame   (ent_frame)
    );

    pw_walk_fsm #(
        .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
        .L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .req_root      (req_root),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .done          (done),
        .done_paddr    (done_paddr),
        .done_fault    (done_fault),
        .va_cur        (va_cur),
        .acc_cur       (acc_cur),
        .top_idx       (top_idx),
        .leaf_idx      (leaf_idx),
        .pg_off        (pg_off),
        .ent_present   (ent_present),
        .ent_allowed   (ent_allowed),
        .ent_changed   (ent_changed),
        .ent_updated   (ent_updated),
        .ent_frame     (ent_frame)
    );

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done && (done_fault == 2'b00) |-> (done_paddr[OFF_BITS-1:0] == pg_off)); // R6

    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_fault != 2'b11)); // R5

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic [19:0] req_root;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [logic [31:0]];

    typedef struct packed {
        logic        wr;
        logic        last;
        logic [31:0] addr;
        logic [31:0] data;
    } op_t;

    typedef struct packed {
        logic [31:0] pa;
        logic [1:0]  flt;
    } res_t;

    op_t  op_q[$];
    res_t res_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // behavioural walk: what the memory traffic and the result must be
    task automatic predict(input logic [31:0] va, input logic [1:0] acc, input logic [19:0] root);
        logic [31:0] a1, e1, a2, e2, nw;
        bit need;
        res_t r;
        a1 = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
        e1 = rd(a1);
        op_q.push_back('{wr: 1'b0, last: !e1[0], addr: a1, data: 32'h0});
        if (!e1[0]) begin
            r.pa = 32'h0; r.flt = 2'b01; res_q.push_back(r);
            return;
        end
        a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
        e2 = rd(a2);
        if (!e2[0]) begin
            op_q.push_back('{wr: 1'b0, last: 1'b1, addr: a2, data: 32'h0});
            r.pa = 32'h0; r.flt = 2'b01; res_q.push_back(r);
            return;
        end
        need = (acc == 2'b01) ? e2[2] : (acc == 2'b10) ? e2[3] : e2[1];
        nw   = e2 | 32'h20 | ((acc == 2'b01) ? 32'h40 : 32'h0);
        op_q.push_back('{wr: 1'b0, last: (!need || nw == e2), addr: a2, data: 32'h0});
        if (!need) begin
            r.pa = 32'h0; r.flt = 2'b10; res_q.push_back(r);
            return;
        end
        if (nw != e2) begin
            op_q.push_back('{wr: 1'b1, last: 1'b1, addr: a2, data: nw});
        end
        r.pa = {e2[31:12], va[11:0]}; r.flt = 2'b00; res_q.push_back(r);
    endtask

    // memory responder and cycle-by-cycle comparison, all at falling edges
    int          stall;
    int          lat;
    bit          rsp_wait;
    bit          rsp_last;
    logic [31:0] rsp_buf;
    bit          done_due;
    bit          hold_prev;
    logic [31:0] hold_addr;

    always @(negedge clk) begin
        if (rst_n !== 1'b1) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEADBEEF;
            done_due = 0; rsp_wait = 0; hold_prev = 0; stall = 0; lat = 0;
        end else begin
            if (hold_prev) begin
                chk(mem_req_valid === 1'b1 && mem_req_addr === hold_addr, "R8",
                    "stalled request not held", {31'h0, mem_req_valid, mem_req_addr},
                    {32'h1, hold_addr});
            end
            hold_prev = 0;
            if (done === 1'b1 || done_due) begin
                chk(done === done_due, "R9", "done timing", {63'h0, done}, {63'h0, done_due});
            end
            if (done === 1'b1) begin
                if (res_q.size() == 0) begin
                    chk(0, "R9", "done without request", {63'h0, done}, 64'h0);
                end else begin
                    res_t r;
                    string tg;
                    r  = res_q.pop_front();
                    tg = (r.flt == 2'b01) ? "R3" : (r.flt == 2'b10) ? "R5" : "R6";
                    chk(done_fault === r.flt, tg, "fault code", {62'h0, done_fault}, {62'h0, r.flt});
                    chk(done_paddr === r.pa, tg, "physical address", {32'h0, done_paddr}, {32'h0, r.pa});
                end
            end
            done_due      = 0;
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEADBEEF;
            mem_req_ready = 1'b0;
            if (rsp_wait) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rsp_buf;
                    rsp_wait      = 0;
                    if (rsp_last) done_due = 1;
                end else begin
                    lat--;
                end
            end else if (mem_req_valid === 1'b1) begin
                if (stall > 0) begin
                    stall--;
                    hold_prev = 1;
                    hold_addr = mem_req_addr;
                end else begin
                    mem_req_ready = 1'b1;
                    if (op_q.size() == 0) begin
                        chk(0, "R3", "unexpected memory access", {31'h0, mem_req_write, mem_req_addr}, 64'h0);
                    end else begin
                        op_t op;
                        op = op_q.pop_front();
                        chk(mem_req_write === op.wr, "R7", "access kind",
                            {63'h0, mem_req_write}, {63'h0, op.wr});
                        chk(mem_req_addr === op.addr, op.wr ? "R7" : "R2", "access address",
                            {32'h0, mem_req_addr}, {32'h0, op.addr});
                        if (op.wr) begin
                            chk(mem_req_wdata === op.data, "R7", "write-back data",
                                {32'h0, mem_req_wdata}, {32'h0, op.data});
                            mem[mem_req_addr] = mem_req_wdata;
                            if (op.last) done_due = 1;
                        end else begin
                            rsp_buf  = rd(mem_req_addr);
                            rsp_last = op.last;
                            rsp_wait = 1;
                            lat      = $urandom_range(0, 4);
                        end
                    end
                    stall = $urandom_range(0, 3);
                end
            end
        end
    end

    // one translation; hold_busy keeps req_valid high with junk while the walk runs
    task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic [19:0] root,
                       input bit hold_busy);
        int n;
        predict(va, acc, root);
        req_vaddr = va; req_acc = acc; req_root = root; req_valid = 1'b1;
        @(negedge clk);
        if (hold_busy) begin
            req_vaddr = ~va; req_acc = 2'b01; req_root = ~root;
        end else begin
            req_valid = 1'b0;
        end
        n = 0;
        while (done !== 1'b1 && n < 400) begin
            chk(req_ready === 1'b0, "R10", "ready while busy", {63'h0, req_ready}, 64'h0);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
    endtask

    localparam logic [19:0] ROOT_A = 20'h00010;
    localparam logic [19:0] ROOT_B = 20'h00030;

    function automatic logic [31:0] ent(input logic [19:0] frame, input int idx);
        return {frame, 12'h000} + idx * 4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_root = '0;
        // top-level table A
        mem[ent(ROOT_A, 0)]    = {20'h00020, 12'h001};
        mem[ent(ROOT_A, 1023)] = {20'h00021, 12'h0FF};   // permission bits set: ignored
        mem[ent(ROOT_A, 5)]    = 32'hFFFFF0FE;           // not present
        // top-level table B
        mem[ent(ROOT_B, 2)]    = {20'h00020, 12'h001};
        // leaf table at frame 0x20
        mem[ent(20'h00020, 0)] = {20'hABCDE, 12'h003};   // read only
        mem[ent(20'h00020, 1)] = {20'h12345, 12'h027};   // rw, used
        mem[ent(20'h00020, 2)] = {20'h0F00F, 12'h009};   // execute only
        mem[ent(20'h00020, 3)] = {20'h55555, 12'h006};   // not present
        mem[ent(20'h00020, 4)] = {20'h33333, 12'h067};   // rw, used, changed
        mem[ent(20'h00020, 6)] = {20'h6789A, 12'h00F};
        // leaf table at frame 0x21
        mem[ent(20'h00021, 0)] = {20'hFEDCB, 12'h00F};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "reset ready", {63'h0, req_ready}, 64'h1);
        chk(done === 1'b0, "R1", "reset done", {63'h0, done}, 64'h0);
        chk(mem_req_valid === 1'b0, "R1", "reset memory request", {63'h0, mem_req_valid}, 64'h0);

        run({10'd0, 10'd0, 12'h123}, 2'b00, ROOT_A, 0);   // R7 used bit written back
        run({10'd0, 10'd0, 12'h456}, 2'b00, ROOT_A, 0);   // R7 no write when unchanged
        run({10'd0, 10'd1, 12'hFFF}, 2'b01, ROOT_A, 0);   // R7 changed bit on write
        run({10'd0, 10'd2, 12'h000}, 2'b10, ROOT_A, 0);   // R5 execute allowed
        run({10'd0, 10'd0, 12'h010}, 2'b01, ROOT_A, 0);   // R5 write to read-only
        run({10'd0, 10'd0, 12'h020}, 2'b10, ROOT_A, 0);   // R5 execute denied
        run({10'd0, 10'd3, 12'h030}, 2'b00, ROOT_A, 0);   // R4 leaf absent
        run({10'd5, 10'd0, 12'h040}, 2'b00, ROOT_A, 0);   // R3 top absent, one read
        run({10'h3FF, 10'd0, 12'h000}, 2'b11, ROOT_A, 0); // R5 code 11 reads, R2 top index max
        run({10'd0, 10'd4, 12'h7FF}, 2'b01, ROOT_A, 0);   // R7 write, nothing changes
        run({10'd0, 10'd6, 12'h5A5}, 2'b01, ROOT_A, 1);   // R10 req_valid held while busy
        run({10'd2, 10'd1, 12'h001}, 2'b00, ROOT_B, 0);   // R2 other root
        run({10'd7, 10'd1, 12'h001}, 2'b00, ROOT_B, 0);   // R3 unmapped

        for (int i = 0; i < 60; i++) begin
            logic [9:0]  t;
            logic [19:0] rt;
            int          s;
            s  = $urandom_range(0, 3);
            t  = (s == 0) ? 10'd0 : (s == 1) ? 10'h3FF : (s == 2) ? 10'd5 : 10'd2;
            rt = ($urandom_range(0, 1) == 0) ? ROOT_A : ROOT_B;
            run({t, 10'($urandom_range(0, 7)), 12'($urandom)}, 2'($urandom_range(0, 3)), rt,
                $urandom_range(0, 1) == 1);
        end

        repeat (4) @(negedge clk);
        chk(op_q.size() == 0, "R3", "accesses left unissued", 64'(op_q.size()), 64'h0);
        chk(res_q.size() == 0, "R9", "results left undelivered", 64'(res_q.size()), 64'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule